// File: doc/BRIEF.md
# CAN receiver path selector with sleep and wake-up control

This block sits between the bus receiver comparators of a CAN controller and its bit-timing logic. It takes three digitized comparator results: wire 0 against wire 1, wire 0 against a mid-supply reference, and the reference against wire 1. It passes them through a synchronizer. Two receiver-select bits pick which comparator drives the receive-data output. A wake-mode bit picks how bus activity is detected.

The block also runs a low-power sleep state. Software requests sleep through a register write. The block only sleeps when the bus is quiet and no controller interrupt is pending. It wakes when software withdraws the request or when the bus becomes active, and every wake raises a one-cycle interrupt pulse. After a wake caused by bus traffic, reception stays disabled until the bus has been recessive for a run of bit strobes. This way the frame that caused the wake is never received in part.

Top module: `can_rx_wake_ctrl`

## Requirements
- R1: Comparator convention: 1 means recessive and 0 means dominant. The receive-data output follows the select pair {sel[1],sel[0]} as follows. 11 gives the wire-to-wire comparator. 01 gives the wire-0 reference comparator. 10 gives the wire-1 reference comparator. 00 holds the output recessive (1).
- R2: Bus activity is set by the wake-mode bit. With the bit at 0, activity means the wire-to-wire comparator is dominant. With the bit at 1, activity means either reference comparator is dominant. Activity is recognised whatever the select pair is.
- R3: Sleep is entered one cycle after all three conditions hold together: the stored sleep request is 1, there is no bus activity, and the pending-interrupt input is low. A request written while these conditions fail is kept, and sleep follows as soon as they hold.
- R4: Sleep is left one cycle after the stored sleep request becomes 0, or one cycle after bus activity is seen while asleep.
- R5: Every exit from sleep raises the wake interrupt for exactly one cycle, in the first awake cycle. At no other time does the wake interrupt rise.
- R6: After a wake caused by bus activity, the reception enable stays low. It rises only after IDLE_BITS consecutive bit strobes (11 by default) sample a recessive receive bit. A dominant sample at a strobe restarts the count. The reception enable is also low while asleep, and it is high at once after a software wake.
- R7: The sleep readback output shows the actual sleep state, not the last value written.
- R8: The select readback shows the current select pair. Writes to the select pair take effect only while the reset-request input is high. At other times they are ignored.
- R9: A wake caused by bus activity clears the stored sleep request, so the block stays awake once the bus goes quiet again.
- R10: After reset, the block is awake and the stored sleep request is 0. The select pair is 11, the wake mode is 0, the reception enable is 1 and the wake interrupt is 0.
- R11: The comparator inputs pass through SYNC_STAGES flip-flops before they reach the receive-data and activity outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_req | input | 1 | Controller reset-request state; enables select writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sleep | input | 1 | Sleep request value written |
| cfg_wmode | input | 1 | Wake mode written (1 single-ended, 0 differential) |
| cfg_sel | input | 2 | Receiver select pair written |
| cmp_diff | input | 1 | Wire 0 versus wire 1 comparator (1 recessive) |
| cmp_w0 | input | 1 | Wire 0 versus reference comparator (1 recessive) |
| cmp_w1 | input | 1 | Reference versus wire 1 comparator (1 recessive) |
| bit_strobe | input | 1 | One-cycle pulse at each bit sample point |
| irq_pending | input | 1 | A controller interrupt is pending |
| rx_data | output | 1 | Selected receive bit |
| bus_active | output | 1 | Bus activity under the current wake mode |
| rx_enable | output | 1 | Reception permitted |
| wake_irq | output | 1 | One-cycle wake-up interrupt |
| sleep_state | output | 1 | Actual sleep state readback |
| sel_rd | output | 2 | Select pair readback |
| wmode_rd | output | 1 | Wake mode readback |

## Verification
The bench builds the block with its defaults: SYNC_STAGES of 2 and IDLE_BITS of 11. The two-stage delay makes the timing of each wake visible cycle by cycle. The full eleven-strobe window lets the bench restart the count with a dominant sample part way through, and it lets the bench probe the strobe just before the limit as well as the strobe at the limit. Random select, wake-mode and comparator patterns drive the routing and activity checks. Directed sequences cover deferred sleep entry, software wake, wake by both detection modes, and ignored select writes.

// File: rtl/can_rxw_pkg.sv
package can_rxw_pkg;
  typedef enum logic {
    PWR_AWAKE  = 1'b0,
    PWR_ASLEEP = 1'b1
  } pwr_state_e;

  localparam logic [1:0] SEL_RESET = 2'b11;
endpackage

// File: rtl/can_rxw_sync.sv
module can_rxw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;
  logic [STAGES-1:0][WIDTH-1:0] pipe_d;

  always_comb begin
    pipe_d[0] = d_in;
    for (int i = 1; i < STAGES; i++) pipe_d[i] = pipe_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_d;
  end

  assign d_out = pipe_q[STAGES-1];
endmodule

// File: rtl/can_rxw_route.sv
module can_rxw_route (
  input  logic [1:0] sel,
  input  logic       wmode,
  input  logic       c_diff,
  input  logic       c_w0,
  input  logic       c_w1,
  output logic       rx_bit,
  output logic       active
);
  always_comb begin
    unique case (sel)
      2'b11:   rx_bit = c_diff;
      2'b01:   rx_bit = c_w0;
      2'b10:   rx_bit = c_w1;
      default: rx_bit = 1'b1;
    endcase
  end

  always_comb begin
    if (wmode) active = !c_w0 || !c_w1;
    else       active = !c_diff;
  end
endmodule

// File: rtl/can_rxw_power_fsm.sv
module can_rxw_power_fsm
  import can_rxw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_sleep,
  input  logic bus_active,
  input  logic irq_pending,
  output logic asleep,
  output logic wake_pulse,
  output logic bus_wake_set
);
  pwr_state_e state_q, state_d;
  logic req_q, req_d;
  logic irq_q, irq_d;

  always_comb begin
    state_d      = state_q;
    req_d        = req_q;
    irq_d        = 1'b0;
    bus_wake_set = 1'b0;
    if (wr_en) req_d = wr_sleep;
    unique case (state_q)
      PWR_AWAKE: begin
        if (req_q && !bus_active && !irq_pending) state_d = PWR_ASLEEP;
      end
      PWR_ASLEEP: begin
        if (bus_active) begin
          state_d      = PWR_AWAKE;
          irq_d        = 1'b1;
          bus_wake_set = 1'b1;
          req_d        = 1'b0;
        end else if (!req_q) begin
          state_d = PWR_AWAKE;
          irq_d   = 1'b1;
        end
      end
      default: state_d = PWR_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PWR_AWAKE;
      req_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      irq_q   <= irq_d;
    end
  end

  assign asleep     = (state_q == PWR_ASLEEP);
  assign wake_pulse = irq_q;

  // R3
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(req_q && !bus_active && !irq_pending));

  // R5
  wake_irq_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> wake_pulse);

  // R5
  wake_irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
endmodule

// File: rtl/can_rxw_idle_gate.sv
module can_rxw_idle_gate #(
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_block,
  input  logic strobe,
  input  logic rx_bit,
  output logic blocked
);
  localparam int CNT_W = $clog2(IDLE_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_BITS - 1);

  logic             blk_q, blk_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    blk_d = blk_q;
    cnt_d = cnt_q;
    if (set_block) begin
      blk_d = 1'b1;
      cnt_d = '0;
    end else if (blk_q && strobe) begin
      if (!rx_bit) begin
        cnt_d = '0;
      end else if (cnt_q == CNT_LAST) begin
        blk_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      blk_q <= blk_d;
      cnt_q <= cnt_d;
    end
  end

  assign blocked = blk_q;

  // R6
  unblock_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blk_q) |-> $past(strobe && rx_bit));

  // R6
  idle_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(IDLE_BITS));
endmodule

// File: rtl/can_rx_wake_ctrl.sv
module can_rx_wake_ctrl
  import can_rxw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_BITS   = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reset_req,
  input  logic       cfg_we,
  input  logic       cfg_sleep,
  input  logic       cfg_wmode,
  input  logic [1:0] cfg_sel,
  input  logic       cmp_diff,
  input  logic       cmp_w0,
  input  logic       cmp_w1,
  input  logic       bit_strobe,
  input  logic       irq_pending,
  output logic       rx_data,
  output logic       bus_active,
  output logic       rx_enable,
  output logic       wake_irq,
  output logic       sleep_state,
  output logic [1:0] sel_rd,
  output logic       wmode_rd
);
  localparam int NCMP = 3;

  logic [1:0]      sel_q, sel_d;
  logic            wmode_q, wmode_d;
  logic [NCMP-1:0] cmp_s;
  logic            asleep, blk, bw_set;

  always_comb begin
    sel_d   = sel_q;
    wmode_d = wmode_q;
    if (cfg_we) begin
      wmode_d = cfg_wmode;
      if (reset_req) sel_d = cfg_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= SEL_RESET;
      wmode_q <= 1'b0;
    end else begin
      sel_q   <= sel_d;
      wmode_q <= wmode_d;
    end
  end

  can_rxw_sync #(.WIDTH(NCMP), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({cmp_w1, cmp_w0, cmp_diff}),
    .d_out (cmp_s)
  );

  can_rxw_route u_route (
    .sel    (sel_q),
    .wmode  (wmode_q),
    .c_diff (cmp_s[0]),
    .c_w0   (cmp_s[1]),
    .c_w1   (cmp_s[2]),
    .rx_bit (rx_data),
    .active (bus_active)
  );

  can_rxw_power_fsm u_pwr (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (cfg_we),
    .wr_sleep     (cfg_sleep),
    .bus_active   (bus_active),
    .irq_pending  (irq_pending),
    .asleep       (asleep),
    .wake_pulse   (wake_irq),
    .bus_wake_set (bw_set)
  );

  can_rxw_idle_gate #(.IDLE_BITS(IDLE_BITS)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_block (bw_set),
    .strobe    (bit_strobe),
    .rx_bit    (rx_data),
    .blocked   (blk)
  );

  assign rx_enable   = !asleep && !blk;
  assign sleep_state = asleep;
  assign sel_rd      = sel_q;
  assign wmode_rd    = wmode_q;

  // R8
  sel_write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(cfg_we) && $past(reset_req)) |-> $stable(sel_q));

  // R6
  block_on_bus_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk) |-> $fell(asleep));
endmodule

// File: tb/tb_can_rx_wake_ctrl.sv
module tb_can_rx_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE_N     = 11;

  logic clk = 1'b0;
  logic rst_n, reset_req, cfg_we, cfg_sleep, cfg_wmode;
  logic [1:0] cfg_sel;
  logic cmp_diff, cmp_w0, cmp_w1, bit_strobe, irq_pending;
  logic rx_data, bus_active, rx_enable, wake_irq, sleep_state, wmode_rd;
  logic [1:0] sel_rd;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_rx_wake_ctrl #(.SYNC_STAGES(2), .IDLE_BITS(IDLE_N)) dut (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .cfg_we(cfg_we),
    .cfg_sleep(cfg_sleep), .cfg_wmode(cfg_wmode), .cfg_sel(cfg_sel),
    .cmp_diff(cmp_diff), .cmp_w0(cmp_w0), .cmp_w1(cmp_w1),
    .bit_strobe(bit_strobe), .irq_pending(irq_pending),
    .rx_data(rx_data), .bus_active(bus_active), .rx_enable(rx_enable),
    .wake_irq(wake_irq), .sleep_state(sleep_state), .sel_rd(sel_rd),
    .wmode_rd(wmode_rd)
  );

  function automatic logic exp_rx(logic [1:0] s, logic d, logic a, logic b);
    case (s)
      2'b11:   return d;
      2'b01:   return a;
      2'b10:   return b;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic exp_act(logic wm, logic d, logic a, logic b);
    return wm ? (!a || !b) : !d;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic sl, input logic wm, input logic [1:0] s);
    cfg_sleep = sl; cfg_wmode = wm; cfg_sel = s; cfg_we = 1'b1;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic strobe_once();
    bit_strobe = 1'b1;
    tick(1);
    bit_strobe = 1'b0;
    tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [1:0] s_cur;
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0; reset_req = 1'b0; cfg_we = 1'b0; cfg_sleep = 1'b0;
    cfg_wmode = 1'b0; cfg_sel = 2'b00; cmp_diff = 1'b1; cmp_w0 = 1'b1;
    cmp_w1 = 1'b1; bit_strobe = 1'b0; irq_pending = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R10 reset state
    check("R10 sleep", sleep_state, 0);
    check("R10 sel", sel_rd, 2'b11);
    check("R10 wmode", wmode_rd, 0);
    check("R10 rx_enable", rx_enable, 1);
    check("R10 wake_irq", wake_irq, 0);

    // R11 latency: a dominant level needs two edges to reach rx_data
    cmp_diff = 1'b0;
    tick(1);
    check("R11 one edge", rx_data, 1);
    tick(1);
    check("R11 two edges", rx_data, 0);
    cmp_diff = 1'b1;
    tick(2);

    // R1 R2 R8 random routing and activity
    reset_req = 1'b1;
    for (int i = 0; i < 150; i++) begin
      logic [1:0] s; logic wm, d, a, b;
      s = 2'($urandom); wm = 1'($urandom);
      d = 1'($urandom); a = 1'($urandom); b = 1'($urandom);
      cfg_write(1'b0, wm, s);
      cmp_diff = d; cmp_w0 = a; cmp_w1 = b;
      tick(2);
      check("R1 rx_data", rx_data, exp_rx(s, d, a, b));
      check("R2 bus_active", bus_active, exp_act(wm, d, a, b));
      check("R8 sel readback", sel_rd, s);
      check("R5 no spurious irq", wake_irq, 0);
    end

    // R8 select writes ignored without reset request
    cmp_diff = 1'b0; cmp_w0 = 1'b1; cmp_w1 = 1'b1;
    cfg_write(1'b0, 1'b0, 2'b11);
    reset_req = 1'b0;
    cfg_write(1'b0, 1'b0, 2'b01);
    tick(2);
    check("R8 ignored sel", sel_rd, 2'b11);
    check("R8 ignored route", rx_data, 0);
    s_cur = sel_rd;
    cmp_diff = 1'b1;
    tick(3);

    // R3 R7 deferred entry: pending interrupt holds off sleep
    irq_pending = 1'b1;
    cfg_write(1'b1, 1'b0, 2'b00);
    tick(3);
    check("R3 irq blocks sleep", sleep_state, 0);
    check("R8 sel unchanged", sel_rd, s_cur);
    cmp_diff = 1'b0;
    tick(3);
    irq_pending = 1'b0;
    tick(3);
    check("R3 activity blocks sleep", sleep_state, 0);
    cmp_diff = 1'b1;
    tick(3);
    check("R3 deferred entry", sleep_state, 1);
    check("R7 readback asleep", sleep_state, 1);
    check("R6 asleep no rx", rx_enable, 0);

    // R4 R5 software wake
    cfg_write(1'b0, 1'b0, 2'b00);
    check("R4 still asleep", sleep_state, 1);
    tick(1);
    check("R4 sw wake", sleep_state, 0);
    check("R5 irq on sw wake", wake_irq, 1);
    check("R6 sw wake rx on", rx_enable, 1);
    tick(1);
    check("R5 irq one cycle", wake_irq, 0);

    // R4 R9 R6 bus wake in differential mode
    cfg_write(1'b1, 1'b0, 2'b00);
    tick(1);
    check("R3 entry", sleep_state, 1);
    cmp_diff = 1'b0;
    tick(2);
    check("R4 not yet", sleep_state, 1);
    tick(1);
    check("R4 bus wake", sleep_state, 0);
    check("R5 irq on bus wake", wake_irq, 1);
    check("R6 blocked", rx_enable, 0);
    cmp_diff = 1'b1;
    tick(3);
    check("R9 stays awake", sleep_state, 0);
    check("R6 still blocked", rx_enable, 0);
    for (int i = 0; i < 5; i++) strobe_once();
    cmp_diff = 1'b0;
    tick(3);
    strobe_once();
    cmp_diff = 1'b1;
    tick(3);
    for (int i = 0; i < IDLE_N - 1; i++) strobe_once();
    check("R6 one short", rx_enable, 0);
    strobe_once();
    check("R6 bus free", rx_enable, 1);

    // R2 differential mode ignores a single-ended disturbance
    cfg_write(1'b1, 1'b0, 2'b00);
    tick(1);
    cmp_w0 = 1'b0;
    tick(4);
    check("R2 diff ignores w0", sleep_state, 1);
    cmp_w0 = 1'b1;
    cfg_write(1'b0, 1'b0, 2'b00);
    tick(2);
    check("R4 sw wake again", sleep_state, 0);

    // R2 R4 single-ended wake on wire 1
    cfg_write(1'b1, 1'b1, 2'b00);
    tick(1);
    check("R3 entry se", sleep_state, 1);
    cmp_w1 = 1'b0;
    tick(3);
    check("R2 se wake", sleep_state, 0);
    check("R5 irq se", wake_irq, 1);
    check("R6 blocked se", rx_enable, 0);
    cmp_w1 = 1'b1;
    tick(3);
    for (int i = 0; i < IDLE_N; i++) strobe_once();
    check("R6 freed se", rx_enable, 1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule